// File: doc/BRIEF.md
# One-time page-size configuration command handler

This block is the command front end of a serial memory for a single job: setting the memory to a binary page size. It listens on an SPI mode-0 link (clock idle low, data sampled on the rising SCK edge, most significant bit first). It recognises one fixed four-byte unlock sequence, sent within a single chip-select frame. When chip select is released exactly after the last bit of that sequence, the block starts a self-timed programming interval. During that interval it reports busy. At the end it sets a one-time-programmable flag that selects 256-byte pages instead of the 264-byte default.

The stored flag is modelled by a register that is cleared only by `rst_n`, which stands for the state at manufacture. A separate `pwr_cycle` pulse models a power-down/power-up. That pulse copies the stored flag into the active page size, clears the SPI framing state and aborts any programming still in progress. The stored flag is visible at once on `status_bit0`. The active page size changes only at a power cycle.

The three SPI pins pass through a synchronizer (`SYNC_STAGES` flops) into the single system clock domain. The programming interval lasts `PROG_CYCLES` system clocks.

Top module: `page_cfg_otp`

## Requirements
- R1: After `rst_n` has been held low, `active_page_size` is 264, `busy` is 0 and `status_bit0` is 0.
- R2: The bytes 0x3D, 0x2A, 0x80, 0xA6 are sent in that order, MSB first, in one chip-select-low frame of exactly 32 SCK rising edges, and chip select then rises. When that happens, `busy` goes high for exactly `PROG_CYCLES` clocks, and `status_bit0` becomes 1 on the clock on which `busy` falls.
- R3: A frame of 32 bits whose bytes differ in value or in order from that sequence does not raise `busy` and does not change `status_bit0`.
- R4: A frame in which chip select rises after any number of SCK rising edges other than 32 causes no programming. This covers a short frame, trailing extra bits and a leading extra byte.
- R5: Chip select high clears the bit count and the match state. A sequence split across two frames causes no programming.
- R6: `active_page_size` changes only on a `pwr_cycle` pulse. At that pulse it takes the value 256 if the stored flag is set and 264 otherwise. Setting the flag alone leaves it at its old value.
- R7: A `pwr_cycle` pulse while `busy` is high ends the interval with the flag unchanged, so `status_bit0` stays 0. A later full command programs normally.
- R8: Once set, the flag never clears except by `rst_n`. Another valid command after it is set does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, models the state at manufacture (clears the stored flag) |
| pwr_cycle | input | 1 | One-clock pulse modelling power-down/up: loads the active size, aborts programming |
| spi_sck | input | 1 | SPI serial clock, idle low, data sampled on its rising edge |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI serial data into the block, MSB first |
| active_page_size | output | 9 | Page size in bytes that is in effect: 264 or 256 |
| busy | output | 1 | High during the self-timed programming interval |
| status_bit0 | output | 1 | Stored one-time flag: 1 means binary page size is configured |

## Verification
A rise on the chip-select pin reaches the design after `SYNC_STAGES` clocks, so with the default of two, `busy` is first seen on the third clock edge after the pin rises. The bench therefore samples five or eight clocks after the frame ends, which is both after any legal rise and before any legal fall. The length of `busy` is measured by counting sampled clocks over a window longer than `PROG_CYCLES` plus the synchronizer delay, and `status_bit0` is checked on the clock after `busy` has fallen. `pwr_cycle` acts on the next clock edge, so the active size and the abort are checked one clock after the pulse. Every expected value is queued by the driver just after a rising edge and compared at the following falling edge, so the outputs are stable when they are read.

// File: rtl/page_cfg_pkg.sv
`timescale 1ns/1ps
// Shared constants for the page-size configuration handler: the unlock
// command bytes and the two page sizes. Assumes a byte-wide serial protocol.
package page_cfg_pkg;
    localparam int CMD_BYTES = 4;
    localparam int CMD_BITS  = CMD_BYTES * 8;
    // Command bytes, first byte in the top octet.
    localparam logic [CMD_BITS-1:0] CMD_SEQ = 32'h3D2A_80A6;
    localparam int PAGE_W = 9;
    localparam logic [PAGE_W-1:0] PAGE_STD = 9'd264;
    localparam logic [PAGE_W-1:0] PAGE_BIN = 9'd256;

    // Expected command byte at position idx (0 = first sent).
    function automatic logic [7:0] cmd_byte(input int idx);
        return CMD_SEQ[(CMD_BYTES - 1 - idx) * 8 +: 8];
    endfunction
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
// Brings the three SPI pins into the system clock domain through a flop
// chain and detects SCK and chip-select rising edges.
// Assumes SCK is several system clocks per half period and that MOSI is
// stable for more than one system clock around each SCK rise.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic cs_n_pin,
    input  logic mosi_pin,
    output logic sck_rise,
    output logic cs_high,
    output logic cs_rise,
    output logic mosi_s
);
    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] IDLE = 3'b010;   // {sck, cs_n, mosi}

    logic [NSIG-1:0] stg [STAGES];
    logic            sck_d, cs_d;

    // Shift the raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= IDLE;
        end else begin
            stg[0] <= {sck_pin, cs_n_pin, mosi_pin};
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    // Keep the previous synchronized SCK and CS for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= stg[STAGES-1][2];
            cs_d  <= stg[STAGES-1][1];
        end
    end

    assign sck_rise = stg[STAGES-1][2] & ~sck_d;
    assign cs_high  = stg[STAGES-1][1];
    assign cs_rise  = stg[STAGES-1][1] & ~cs_d;
    assign mosi_s   = stg[STAGES-1][0];
endmodule

// File: rtl/cmd_seq_matcher.sv
`timescale 1ns/1ps
// Counts bits in one chip-select frame and compares each completed byte
// against the unlock command. Requests programming when chip select rises
// after exactly the command length with every byte matched.
// Assumes synchronized inputs from spi_pin_sync.
module cmd_seq_matcher
    import page_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sck_rise,
    input  logic cs_high,
    input  logic cs_rise,
    input  logic mosi_s,
    output logic prog_req
);
    localparam int CNT_W = $clog2(CMD_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CMD_BITS + 1);

    logic [CNT_W-1:0] bit_cnt;
    logic [6:0]       shreg;
    logic             all_ok;
    logic [7:0]       next_byte;

    assign next_byte = {shreg, mosi_s};

    // Track bit count, shift data and clear the match flag on any bad byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || cs_high) begin
            bit_cnt <= '0;
            shreg   <= '0;
            all_ok  <= 1'b1;
        end else if (sck_rise) begin
            shreg <= next_byte[6:0];
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt[2:0] == 3'd7 && bit_cnt < CNT_FULL &&
                next_byte != cmd_byte(int'(bit_cnt >> 3)))
                all_ok <= 1'b0;
        end
    end

    assign prog_req = cs_rise && all_ok && (bit_cnt == CNT_FULL);

    // R5: chip select high leaves the frame state cleared.
    p_frame_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_high |=> (bit_cnt == '0 && all_ok));
endmodule

// File: rtl/prog_timer.sv
`timescale 1ns/1ps
// Self-timed programming interval: busy for exactly CYCLES clocks after a
// start pulse, with a one-cycle done strobe on the last busy clock.
// An abort ends the interval without a done strobe. Assumes CYCLES >= 2.
module prog_timer #(
    parameter int CYCLES = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    // Load the counter on start and count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= LOAD;
        end
    end

    assign done = busy && (cnt == '0) && !abort;

    // R2: busy only ends after the full count or by an abort.
    p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(cnt) == '0 || $past(abort)));
endmodule

// File: rtl/page_cfg_otp.sv
`timescale 1ns/1ps
// Page-size configuration command handler. Holds the one-time flag
// (cleared only by rst_n, modelling manufacture) and the active page size
// that is loaded from the flag on each power-cycle pulse.
// Assumes pwr_cycle is a synchronous one-clock pulse.
module page_cfg_otp
    import page_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PROG_CYCLES = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_cycle,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic [PAGE_W-1:0] active_page_size,
    output logic              busy,
    output logic              status_bit0
);
    logic sck_rise, cs_high, cs_rise, mosi_s;
    logic prog_req, prog_start, prog_done;
    logic otp_flag, active_bin;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_pin(spi_sck), .cs_n_pin(spi_cs_n), .mosi_pin(spi_mosi),
        .sck_rise(sck_rise), .cs_high(cs_high), .cs_rise(cs_rise),
        .mosi_s(mosi_s)
    );

    cmd_seq_matcher u_match (
        .clk(clk), .rst_n(rst_n), .clear(pwr_cycle),
        .sck_rise(sck_rise), .cs_high(cs_high), .cs_rise(cs_rise),
        .mosi_s(mosi_s), .prog_req(prog_req)
    );

    // Start only when idle, not yet programmed and not being power-cycled.
    assign prog_start = prog_req && !busy && !otp_flag && !pwr_cycle;

    prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .abort(pwr_cycle),
        .busy(busy), .done(prog_done)
    );

    // Nonvolatile flag: set once at the end of programming.
    always_ff @(posedge clk) begin
        if (!rst_n)         otp_flag <= 1'b0;
        else if (prog_done) otp_flag <= 1'b1;
    end

    // Active page size is sampled from the flag at each power cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         active_bin <= 1'b0;
        else if (pwr_cycle) active_bin <= otp_flag;
    end

    assign active_page_size = active_bin ? PAGE_BIN : PAGE_STD;
    assign status_bit0      = otp_flag;

    // R8: the flag never clears once set.
    p_otp_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        otp_flag |=> otp_flag);
    // R8: programming never starts on an already-set flag.
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(otp_flag));
    // R2: the flag is set exactly when the busy interval finishes.
    p_set_at_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(otp_flag) |-> $fell(busy));
    // R6: the active size moves only on a power-cycle pulse.
    p_active_on_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_bin) |-> $past(pwr_cycle));
endmodule

// File: tb/page_cfg_otp_tb_top.sv
`timescale 1ns/1ps
module page_cfg_otp_tb_top;
    localparam int TP   = 50;
    localparam int HALF = 4;          // system clocks per SCK half period
    localparam int WDOG = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_cycle = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [8:0] page;
    logic       busy, stat;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    typedef struct {
        string req;
        int    page;
        bit    busy;
        bit    stat;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    page_cfg_otp #(.SYNC_STAGES(2), .PROG_CYCLES(TP)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle),
        .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .active_page_size(page), .busy(busy), .status_bit0(stat)
    );

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (int'(page) != e.page || busy != e.busy || stat != e.stat) begin
                n_fail++;
                $display("FAIL %s: page=%0d busy=%0b status=%0b expected page=%0d busy=%0b status=%0b",
                         e.req, page, busy, stat, e.page, e.busy, e.stat);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    // Driver side of the scoreboard: queue the outputs due in this cycle.
    task automatic expect_out(input string req, input int pg, input bit b, input bit s);
        exp_t e;
        @(posedge clk); #1;
        e.req = req; e.page = pg; e.busy = b; e.stat = s;
        sb_q.push_back(e);
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One SPI mode-0 frame of nbits bits, MSB first, from the low end of data.
    task automatic spi_frame(input logic [63:0] data, input int nbits);
        wait_clk(1);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = data[i];
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
    endtask

    task automatic pulse_pwr();
        @(posedge clk); #1;
        pwr_cycle = 1'b1;
        @(posedge clk); #1;
        pwr_cycle = 1'b0;
    endtask

    // Count sampled busy cycles over a window longer than any interval.
    task automatic measure_busy(input string req, input int exp);
        int n = 0;
        for (int i = 0; i < TP + 30; i++) begin
            @(posedge clk); #1;
            if (busy) n++;
        end
        check_int(req, n, exp);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        expect_out("R1 reset state", 264, 0, 0);

        spi_frame(64'h3D2A_80A7, 32);
        wait_clk(8);
        expect_out("R3 wrong last byte", 264, 0, 0);

        spi_frame(64'h2A3D_80A6, 32);
        wait_clk(8);
        expect_out("R3 swapped bytes", 264, 0, 0);

        spi_frame(64'h3D_2A80, 24);
        wait_clk(8);
        expect_out("R4 short frame", 264, 0, 0);

        spi_frame({31'd0, 32'h3D2A_80A6, 1'b0}, 33);
        wait_clk(8);
        expect_out("R4 extra trailing bit", 264, 0, 0);

        spi_frame(64'h00_3D2A_80A6, 40);
        wait_clk(8);
        expect_out("R4 leading extra byte", 264, 0, 0);

        spi_frame(64'h3D2A, 16);
        wait_clk(4);
        spi_frame(64'h80A6, 16);
        wait_clk(8);
        expect_out("R5 split frames", 264, 0, 0);

        // Start, then abort by power cycle.
        spi_frame(64'h3D2A_80A6, 32);
        wait_clk(5);
        expect_out("R2 busy after valid command", 264, 1, 0);
        wait_clk(10);
        pulse_pwr();
        expect_out("R7 abort leaves flag clear", 264, 0, 0);

        // Full program cycle.
        spi_frame(64'h3D2A_80A6, 32);
        measure_busy("R2 busy length", TP);
        expect_out("R2 R6 flag set, active unchanged", 264, 0, 1);

        pulse_pwr();
        expect_out("R6 binary page after power cycle", 256, 0, 1);

        spi_frame(64'h3D2A_80A6, 32);
        measure_busy("R8 no busy once programmed", 0);
        expect_out("R8 flag kept", 256, 0, 1);

        pulse_pwr();
        expect_out("R8 flag survives power cycle", 256, 0, 1);

        wait_clk(3);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule